// File: doc/BRIEF.md
# PCI interrupt line router

This block steers four shared PCI interrupt request lines onto the sixteen inputs of a legacy interrupt controller. Each request line has its own byte-wide routing register. A value below sixteen in that register names the controller input the line drives. A value of sixteen or more switches the line off. The routing registers sit in one 32-bit word at byte address 0x60, with line A in the lowest byte through line D in the highest. A plain write/read port with byte enables reaches them, so one word write can retarget all four lines at once.

Internally the block keeps a 4×16 level bitmap with one bit per (controller input, request line) pair. While the routing is unchanged, every enabled line's current level is copied into its bit. Each controller output is registered and is the OR of the four bits that belong to it. Any write that lands on a routing byte sets up a rebuild for the next clock. The rebuild clears the bitmap and refills it from the present line levels under the new routing, so a stale bit can never hold an output high after a line has moved.

Two small side paths complete the block. A combinational helper maps a device's slot number and interrupt pin onto one of the four lines, using the usual rotation. A combinational route-query port reports, for any line, whether it is enabled and which output it drives.

Top module: `intx_line_router`

## Requirements
- R1: After reset every routing byte reads 0x80, every line is disabled, the route query reports disabled, and all sixteen outputs are low.
- R2: A write whose address is the routing word (byte address 0x60) stores data byte i into the routing register of line i (A=0 … D=3) for each lane i whose byte enable is set. Lanes whose enable is clear keep their value, and writes to any other address change nothing.
- R3: A read at byte address 0x60 returns the four stored routing bytes unchanged, including any bits above the output number. A read at any other address returns zero.
- R4: A line whose routing byte is 16 or more has no effect on any output, whatever its level.
- R5: Output k is the OR of the levels of all enabled lines routed to k. A level applied before clock edge E appears on the outputs after edge E+1.
- R6: After a routing write captured at edge T, the outputs still show the old routing after edges T and T+1. After edge T+2 they show exactly the new routing applied to the current line levels, and any output that only the old routing drove goes low.
- R7: The swizzle output is (pin + slot − 1) mod 4, where pin 0..3 stands for pins A..D and slot is the device number. Slot 0 with pin A therefore gives line 3.
- R8: The route query returns enabled = (routing byte < 16) for the selected line, together with the low four bits of that byte as the output number.
- R9: When two enabled lines share one output, that output stays high as long as either line is high, and it drops only when both are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_level_i | input | 4 | Current level of request lines A..D (bit 0 = A) |
| cfg_wr_en_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 8 | Byte address of the 32-bit register word |
| cfg_wdata_i | input | 32 | Write data |
| cfg_be_i | input | 4 | Byte enables for the write |
| cfg_rdata_o | output | 32 | Combinational read data for cfg_addr_i |
| query_line_i | input | 2 | Line selected for the route query |
| query_en_o | output | 1 | Selected line is enabled |
| query_dst_o | output | 4 | Output number of the selected line |
| swz_slot_i | input | 5 | Device slot number for the swizzle helper |
| swz_pin_i | input | 2 | Device interrupt pin (0 = A) |
| swz_line_o | output | 2 | Request line used by that slot and pin |
| irq_o | output | 16 | Registered controller outputs |

## Verification
The bench goes after a line that is moved while it is held high. A design that patched only the new bit would leave the old output stuck on, and one that rebuilt too early or too late would switch outputs a cycle off from R6. It also drives routing bytes such as 0x4F and 0x10: a design that compared only the low nibble would wrongly enable output 15 or 0 there, and one that masked stored bits would fail the readback. Shared outputs with one line falling catch a design that clears a whole output instead of a single bit. Slot 0 catches a swizzle that does not wrap below zero.

// File: rtl/intx_router_pkg.sv
`timescale 1ns/1ps
package intx_router_pkg;

  // One routing register per request line
  typedef logic [7:0] route_byte_t;

  // Reset value: bit 7 set, which is above every valid output number
  localparam route_byte_t ROUTE_OFF = 8'h80;

  // Bitmap update mode for the coming clock
  typedef enum logic {
    MAP_TRACK   = 1'b0,
    MAP_REBUILD = 1'b1
  } map_phase_e;

endpackage

// File: rtl/intx_route_regs.sv
`timescale 1ns/1ps
module intx_route_regs
  import intx_router_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS  = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int REG_BASE  = 96,
  parameter int OUT_W     = $clog2(NUM_OUTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  input  logic [DATA_W/8-1:0]   be,
  output logic [DATA_W-1:0]     rdata,
  output logic [NUM_LINES-1:0]  route_en,
  output logic [OUT_W-1:0]      route_dst [NUM_LINES],
  output logic                  wr_hit
);

  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);
  localparam int WORD_W = ADDR_W - LANE_W;
  localparam route_byte_t OUT_LIMIT = route_byte_t'(NUM_OUTS);

  route_byte_t             regs_q [NUM_LINES];
  logic [NUM_LINES-1:0]    hit;
  logic [WORD_W-1:0]       word_sel;

  assign word_sel = addr[ADDR_W-1:LANE_W];

  generate
    for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
      localparam int BYTE_ADDR = REG_BASE + l;
      localparam int WORD_IDX  = BYTE_ADDR / LANES;
      localparam int LANE_IDX  = BYTE_ADDR % LANES;

      assign hit[l] = wr_en && (word_sel == WORD_W'(WORD_IDX)) && be[LANE_IDX];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          regs_q[l] <= ROUTE_OFF;
        end else if (hit[l]) begin
          regs_q[l] <= wdata[LANE_IDX*8 +: 8];
        end
      end

      assign route_en[l]  = (regs_q[l] < OUT_LIMIT);
      assign route_dst[l] = regs_q[l][OUT_W-1:0];
    end
  endgenerate

  assign wr_hit = |hit;

  // Read path: each lane returns the routing byte living at its address
  always_comb begin
    rdata = '0;
    for (int b = 0; b < LANES; b++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if ({word_sel, LANE_W'(b)} == ADDR_W'(REG_BASE + l)) begin
          rdata[b*8 +: 8] = regs_q[l];
        end
      end
    end
  end

endmodule

// File: rtl/intx_level_map.sv
`timescale 1ns/1ps
module intx_level_map
  import intx_router_pkg::*;
#(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS  = 16,
  parameter int OUT_W     = $clog2(NUM_OUTS)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_LINES-1:0]           level,
  input  logic [NUM_LINES-1:0]           route_en,
  input  logic [OUT_W-1:0]               route_dst [NUM_LINES],
  input  logic                           rebuild_req,
  output logic [NUM_OUTS*NUM_LINES-1:0]  map_o
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int MAP_W  = NUM_OUTS * NUM_LINES;

  map_phase_e          phase_q;
  logic [MAP_W-1:0]    map_q;
  logic [MAP_W-1:0]    map_d;

  // Bit index is output*NUM_LINES + line; with power-of-two line count
  // that is the concatenation {output, line}.
  always_comb begin
    map_d = (phase_q == MAP_REBUILD) ? '0 : map_q;
    for (int l = 0; l < NUM_LINES; l++) begin
      if (route_en[l]) begin
        map_d[{route_dst[l], LINE_W'(l)}] = level[l];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_q   <= '0;
      phase_q <= MAP_TRACK;
    end else begin
      map_q   <= map_d;
      phase_q <= rebuild_req ? MAP_REBUILD : MAP_TRACK;
    end
  end

  assign map_o = map_q;

endmodule

// File: rtl/intx_output_or.sv
`timescale 1ns/1ps
module intx_output_or #(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS  = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_OUTS*NUM_LINES-1:0]  map_i,
  output logic [NUM_OUTS-1:0]            irq_o
);

  logic [NUM_OUTS-1:0] irq_q;

  generate
    for (genvar o = 0; o < NUM_OUTS; o++) begin : g_out
      logic [NUM_LINES-1:0] grp;
      assign grp = map_i[o*NUM_LINES +: NUM_LINES];

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          irq_q[o] <= 1'b0;
        end else begin
          irq_q[o] <= |grp;
        end
      end
    end
  endgenerate

  assign irq_o = irq_q;

endmodule

// File: rtl/intx_slot_swizzle.sv
`timescale 1ns/1ps
module intx_slot_swizzle #(
  parameter int NUM_LINES = 4,
  parameter int SLOT_W    = 5,
  parameter int LINE_W    = $clog2(NUM_LINES)
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [LINE_W-1:0] pin,
  output logic [LINE_W-1:0] line
);

  logic [LINE_W-1:0] slot_low;

  assign slot_low = slot[LINE_W-1:0];
  // Rotation wraps modulo the line count through truncation
  assign line = pin + slot_low - LINE_W'(1);

endmodule

// File: rtl/intx_line_router.sv
`timescale 1ns/1ps
module intx_line_router #(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS  = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int REG_BASE  = 96,
  parameter int SLOT_W    = 5,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int OUT_W     = $clog2(NUM_OUTS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_LINES-1:0]  line_level_i,
  input  logic                  cfg_wr_en_i,
  input  logic [ADDR_W-1:0]     cfg_addr_i,
  input  logic [DATA_W-1:0]     cfg_wdata_i,
  input  logic [DATA_W/8-1:0]   cfg_be_i,
  output logic [DATA_W-1:0]     cfg_rdata_o,
  input  logic [LINE_W-1:0]     query_line_i,
  output logic                  query_en_o,
  output logic [OUT_W-1:0]      query_dst_o,
  input  logic [SLOT_W-1:0]     swz_slot_i,
  input  logic [LINE_W-1:0]     swz_pin_i,
  output logic [LINE_W-1:0]     swz_line_o,
  output logic [NUM_OUTS-1:0]   irq_o
);

  localparam int MAP_W = NUM_OUTS * NUM_LINES;

  logic [NUM_LINES-1:0] route_en;
  logic [OUT_W-1:0]     route_dst [NUM_LINES];
  logic                 wr_hit;
  logic [MAP_W-1:0]     level_map;

  intx_route_regs #(
    .NUM_LINES (NUM_LINES),
    .NUM_OUTS  (NUM_OUTS),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .REG_BASE  (REG_BASE),
    .OUT_W     (OUT_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr_en_i),
    .addr      (cfg_addr_i),
    .wdata     (cfg_wdata_i),
    .be        (cfg_be_i),
    .rdata     (cfg_rdata_o),
    .route_en  (route_en),
    .route_dst (route_dst),
    .wr_hit    (wr_hit)
  );

  intx_level_map #(
    .NUM_LINES (NUM_LINES),
    .NUM_OUTS  (NUM_OUTS),
    .OUT_W     (OUT_W)
  ) u_map (
    .clk         (clk),
    .rst_n       (rst_n),
    .level       (line_level_i),
    .route_en    (route_en),
    .route_dst   (route_dst),
    .rebuild_req (wr_hit),
    .map_o       (level_map)
  );

  intx_output_or #(
    .NUM_LINES (NUM_LINES),
    .NUM_OUTS  (NUM_OUTS)
  ) u_or (
    .clk   (clk),
    .rst_n (rst_n),
    .map_i (level_map),
    .irq_o (irq_o)
  );

  intx_slot_swizzle #(
    .NUM_LINES (NUM_LINES),
    .SLOT_W    (SLOT_W),
    .LINE_W    (LINE_W)
  ) u_swz (
    .slot (swz_slot_i),
    .pin  (swz_pin_i),
    .line (swz_line_o)
  );

  assign query_en_o  = route_en[query_line_i];
  assign query_dst_o = route_dst[query_line_i];

endmodule

// File: rtl/intx_line_router_chk.sv
`timescale 1ns/1ps
module intx_line_router_chk #(
  parameter int NUM_LINES = 4,
  parameter int NUM_OUTS  = 16,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int REG_BASE  = 96,
  parameter int SLOT_W    = 5,
  parameter int LINE_W    = $clog2(NUM_LINES),
  parameter int OUT_W     = $clog2(NUM_OUTS)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_LINES-1:0]  line_level_i,
  input logic                  cfg_wr_en_i,
  input logic [ADDR_W-1:0]     cfg_addr_i,
  input logic [DATA_W-1:0]     cfg_wdata_i,
  input logic [DATA_W/8-1:0]   cfg_be_i,
  input logic [DATA_W-1:0]     cfg_rdata_o,
  input logic [LINE_W-1:0]     query_line_i,
  input logic                  query_en_o,
  input logic [OUT_W-1:0]      query_dst_o,
  input logic [SLOT_W-1:0]     swz_slot_i,
  input logic [LINE_W-1:0]     swz_pin_i,
  input logic [LINE_W-1:0]     swz_line_o,
  input logic [NUM_OUTS-1:0]   irq_o
);

  localparam logic [7:0] OUT_LIMIT = 8'(NUM_OUTS);

  logic       at_base;
  logic [7:0] q_byte;

  assign at_base = (cfg_addr_i == ADDR_W'(REG_BASE));
  // Assumes the routing word is aligned and one lane per line
  assign q_byte  = cfg_rdata_o[{query_line_i, 3'b000} +: 8];

  // R1: leaving reset, outputs are quiet and the queried line is off
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irq_o == '0 && !query_en_o));

  // R2: a full-word write to the routing word reads back next cycle
  assert_write_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_en_i && at_base && (&cfg_be_i)) |=>
      (!at_base || cfg_rdata_o == $past(cfg_wdata_i)));

  // R5: lines all low two edges back leaves every output low
  assert_low_lines_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_level_i, 2) == '0) |-> (irq_o == '0));

  // R6: steady levels and no routing write leave the outputs unchanged
  assert_steady_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(line_level_i, 2) == $past(line_level_i, 3)) && !$past(cfg_wr_en_i, 3))
      |-> $stable(irq_o));

  // R7: slot 1 is the identity rotation
  assert_swizzle_identity_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (swz_slot_i == SLOT_W'(1)) |-> (swz_line_o == swz_pin_i));

  // R8: the query agrees with the stored byte seen through the read port
  assert_query_matches_R8: assert property (@(posedge clk) disable iff (!rst_n)
    at_base |-> ((query_en_o == (q_byte < OUT_LIMIT)) &&
                 (query_dst_o == q_byte[OUT_W-1:0])));

endmodule

bind intx_line_router intx_line_router_chk #(
  .NUM_LINES (NUM_LINES),
  .NUM_OUTS  (NUM_OUTS),
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .REG_BASE  (REG_BASE),
  .SLOT_W    (SLOT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .line_level_i (line_level_i),
  .cfg_wr_en_i  (cfg_wr_en_i),
  .cfg_addr_i   (cfg_addr_i),
  .cfg_wdata_i  (cfg_wdata_i),
  .cfg_be_i     (cfg_be_i),
  .cfg_rdata_o  (cfg_rdata_o),
  .query_line_i (query_line_i),
  .query_en_o   (query_en_o),
  .query_dst_o  (query_dst_o),
  .swz_slot_i   (swz_slot_i),
  .swz_pin_i    (swz_pin_i),
  .swz_line_o   (swz_line_o),
  .irq_o        (irq_o)
);

// File: tb/intx_line_router_test.sv
`timescale 1ns/1ps
module intx_line_router_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  line_level = '0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = 8'h60;
  logic [31:0] cfg_wdata = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  query_line = '0;
  logic        query_en;
  logic [3:0]  query_dst;
  logic [4:0]  swz_slot = 5'd1;
  logic [1:0]  swz_pin = '0;
  logic [1:0]  swz_line;
  logic [15:0] irq;

  int checks = 0;
  int bad = 0;
  bit started = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intx_line_router uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .line_level_i (line_level),
    .cfg_wr_en_i  (cfg_wr_en),
    .cfg_addr_i   (cfg_addr),
    .cfg_wdata_i  (cfg_wdata),
    .cfg_be_i     (cfg_be),
    .cfg_rdata_o  (cfg_rdata),
    .query_line_i (query_line),
    .query_en_o   (query_en),
    .query_dst_o  (query_dst),
    .swz_slot_i   (swz_slot),
    .swz_pin_i    (swz_pin),
    .swz_line_o   (swz_line),
    .irq_o        (irq)
  );

  // Behavioural reference: routing bytes, 64-entry level map, output word
  int        m_route [4];
  bit        m_map [64];
  bit [15:0] m_irq;
  bit        m_rebuild;

  always @(posedge clk) begin
    bit [15:0] nxt;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_route[i] = 'h80;
      for (int i = 0; i < 64; i++) m_map[i] = 0;
      m_irq = '0;
      m_rebuild = 0;
    end else begin
      for (int k = 0; k < 16; k++)
        nxt[k] = m_map[k*4] | m_map[k*4+1] | m_map[k*4+2] | m_map[k*4+3];
      if (m_rebuild)
        for (int i = 0; i < 64; i++) m_map[i] = 0;
      for (int l = 0; l < 4; l++)
        if (m_route[l] < 16) m_map[m_route[l]*4 + l] = line_level[l];
      m_rebuild = 0;
      if (cfg_wr_en && cfg_addr[7:2] == 6'h18)
        for (int b = 0; b < 4; b++)
          if (cfg_be[b]) begin
            m_route[b] = int'(cfg_wdata[b*8 +: 8]);
            m_rebuild = 1;
          end
      m_irq = nxt;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the reference, away from the edge
  always @(negedge clk) begin
    #2;
    if (started && rst_n && !done) begin
      logic [31:0] exp_rd;
      int          qr;
      exp_rd = '0;
      if (cfg_addr[7:2] == 6'h18)
        for (int b = 0; b < 4; b++) exp_rd[b*8 +: 8] = 8'(m_route[b]);
      qr = m_route[query_line];
      chk("R5 irq vs model", {16'h0, irq}, {16'h0, m_irq});
      chk("R3 rdata vs model", cfg_rdata, exp_rd);
      chk("R8 query vs model", {27'h0, query_en, query_dst},
          {27'h0, (qr < 16), 4'(qr)});
      chk("R7 swizzle vs model", {30'h0, swz_line},
          {30'h0, 2'((int'(swz_pin) + int'(swz_slot) - 1) & 3)});
    end
  end

  task automatic cfg_write(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr_en = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    cfg_be    = be;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    cfg_be    = '0;
    cfg_addr  = 8'h60;
  endtask

  task automatic set_level(input logic [3:0] v);
    @(negedge clk);
    line_level = v;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    #3;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog expired, run did not complete");
      done = 1;
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    started = 1;
    #3;
    chk("R1 reset routing bytes", cfg_rdata, 32'h80808080);
    chk("R1 reset outputs", {16'h0, irq}, 32'h0);
    chk("R1 reset query disabled", {31'h0, query_en}, 32'h0);

    // Line A to output 5 through a single-lane write
    cfg_write(8'h60, 32'h00000005, 4'b0001);
    #3;
    chk("R2 lane A written only", cfg_rdata, 32'h80808005);
    set_level(4'b0001);
    settle();
    chk("R5 line A drives output 5", {16'h0, irq}, 32'h00000020);

    // Line B shares output 5
    cfg_write(8'h60, 32'h00000500, 4'b0010);
    settle();
    set_level(4'b0011);
    settle();
    chk("R9 both lines high", {16'h0, irq}, 32'h00000020);
    set_level(4'b0010);
    settle();
    chk("R9 one of two lines still high", {16'h0, irq}, 32'h00000020);
    set_level(4'b0000);
    settle();
    chk("R9 both lines low", {16'h0, irq}, 32'h0);

    // Line C gets 0x4F: disabled, but stored as written
    cfg_write(8'h60, 32'h004F0000, 4'b0100);
    #3;
    chk("R3 readback keeps upper bits", cfg_rdata, 32'h804F0505);
    query_line = 2'd2;
    #1;
    chk("R8 query 0x4F disabled", {31'h0, query_en}, 32'h0);
    chk("R8 query output nibble", {28'h0, query_dst}, 32'h0000000F);
    set_level(4'b0100);
    settle();
    chk("R4 disabled line no output", {16'h0, irq}, 32'h0);

    // Enable C onto output 15: exact timing of the rebuild
    cfg_write(8'h60, 32'h000F0000, 4'b0100);
    #3;
    chk("R6 old routing after write edge", {16'h0, irq}, 32'h0);
    @(negedge clk); #3;
    chk("R6 old routing one edge later", {16'h0, irq}, 32'h0);
    @(negedge clk); #3;
    chk("R6 new routing two edges later", {16'h0, irq}, 32'h00008000);
    chk("R8 query enabled", {31'h0, query_en}, 32'h1);

    // Move line A from 5 to 3 while it is high
    set_level(4'b0101);
    settle();
    chk("R5 lines A and C", {16'h0, irq}, 32'h00008020);
    cfg_write(8'h60, 32'h00000003, 4'b0001);
    @(negedge clk); #3;
    chk("R6 before rebuild", {16'h0, irq}, 32'h00008020);
    @(negedge clk); #3;
    chk("R6 old output dropped, new raised", {16'h0, irq}, 32'h00008008);

    // Write to a neighbouring word is ignored
    cfg_write(8'h64, 32'hFFFFFFFF, 4'hF);
    settle();
    chk("R2 other address ignored", cfg_rdata, 32'h800F0503);
    chk("R2 outputs unchanged", {16'h0, irq}, 32'h00008008);
    cfg_addr = 8'h64;
    #1;
    chk("R3 other address reads zero", cfg_rdata, 32'h0);
    cfg_addr = 8'h60;

    // One word write retargets all four lines
    cfg_write(8'h60, 32'h00010203, 4'hF);
    set_level(4'b1111);
    settle();
    chk("R2 full word write", cfg_rdata, 32'h00010203);
    chk("R5 four lines to outputs 3..0", {16'h0, irq}, 32'h0000000F);

    // Every byte 16 or above: all disabled
    cfg_write(8'h60, 32'h10FF2080, 4'hF);
    settle();
    chk("R4 all lines disabled", {16'h0, irq}, 32'h0);
    chk("R3 readback of disabled values", cfg_rdata, 32'h10FF2080);

    // Swizzle corner cases
    swz_slot = 5'd1;  swz_pin = 2'd0; #1;
    chk("R7 slot 1 pin A", {30'h0, swz_line}, 32'd0);
    swz_slot = 5'd0;  swz_pin = 2'd0; #1;
    chk("R7 slot 0 wraps", {30'h0, swz_line}, 32'd3);
    swz_slot = 5'd5;  swz_pin = 2'd2; #1;
    chk("R7 slot 5 pin C", {30'h0, swz_line}, 32'd2);
    swz_slot = 5'd31; swz_pin = 2'd3; #1;
    chk("R7 slot 31 pin D", {30'h0, swz_line}, 32'd1);
    swz_slot = 5'd2;  swz_pin = 2'd1; #1;
    chk("R7 slot 2 pin B", {30'h0, swz_line}, 32'd2);

    // Mixed traffic, checked against the reference every clock
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      line_level = 4'($urandom);
      query_line = 2'($urandom);
      swz_slot   = 5'($urandom);
      swz_pin    = 2'($urandom);
      if ($urandom % 4 == 0) begin
        logic [31:0] d;
        logic [7:0]  a;
        for (int b = 0; b < 4; b++)
          d[b*8 +: 8] = ($urandom % 3 == 0) ? 8'h80 : 8'($urandom % 20);
        case ($urandom % 4)
          0: a = 8'h64;
          1: a = 8'h5C;
          default: a = 8'h60;
        endcase
        cfg_write(a, d, 4'($urandom));
      end
      repeat ($urandom % 4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    #4;
    done = 1;
    finish_run();
  end

endmodule